// File: doc/BRIEF.md
# Self-Inverting Word Memory

This block is a word-organised memory of 1024 words of 8 bits, arranged as a grid of 32 rows by 32 columns. The high address bits select a row and the low bits select a column, and the two are decoded separately. Every stored bit is inverted at regular intervals, so that no storage element keeps one value long enough to imprint it. Each inversion is a two-step transfer. A load strobe puts the complement of every stored word into a shadow (master) stage. A later copy strobe moves the shadow back into storage.

A single polarity bit records how many inversions have completed, modulo two. Writes store the incoming data XORed with that bit, and reads XOR it back out, so the inversion cannot be seen at the data ports. A one-cycle erase clears all storage, every shadow word and the polarity bit. The toggle strobes come either from two input pins or, when a parameter selects it, from an internal sequencer that runs one load/copy pair every `TOGGLE_PERIOD` cycles.

Data moves through plain strobes, with no valid/ready handshake. A write is accepted in every cycle except an erase cycle. Read data appears one cycle after the read strobe and holds its value until the next read or erase, so the consumer never applies back-pressure.

Top module: `flipcell_ram`

## Requirements
- R1: A write stores `wr_data` at the word addressed by `addr` (row = upper `ROW_BITS` bits, column = lower `COL_BITS` bits). A later read of that address returns the same byte.
- R2: When `rd_en` and `wr_en` are both high in one cycle, the write takes effect and the read returns the contents from before that write.
- R3: Any number of completed inversions leaves the data read at every address unchanged.
- R4: `inv_state` flips in the cycle after a copy strobe only if a load strobe has arrived since the last copy or erase. A copy strobe without such a load changes neither `inv_state` nor the data.
- R5: A cycle with both toggle strobes high performs no load and no copy. `phase_err` is high for exactly the following cycle. A write in that cycle still takes effect.
- R6: After an erase cycle every address reads 0 and `inv_state` is 0. `rd_data` is 0 in the cycle after the erase, and a write or read issued in the erase cycle is ignored.
- R7: A write in the same cycle as a copy strobe, in the same cycle as a load strobe, or between a load and its copy is not lost.
- R8: `rd_data` is registered with one cycle of latency and holds its value when neither `rd_en` nor erase is asserted.
- R9: With `INT_TOGGLE=1` the toggle pins are ignored. An internal sequencer issues a load, then one idle cycle, then a copy, so `inv_state` flips once every `TOGGLE_PERIOD` cycles and stored data stays readable.
- R10: After reset `rd_data` is 0, `inv_state` is 0 and `phase_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state and read register |
| addr | input | ROW_BITS+COL_BITS | Word address: row in the upper bits, column in the lower bits |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Data to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Registered read data |
| erase | input | 1 | Whole-array clear in one cycle |
| tgl_copy | input | 1 | Copy strobe (shadow stage to storage) |
| tgl_load | input | 1 | Load strobe (inverted storage to shadow stage) |
| inv_state | output | 1 | Current storage polarity |
| phase_err | output | 1 | One-cycle pulse after both toggle strobes were high together |

## Verification
The bench targets writes that land in the same cycle as a copy strobe and writes that land between a load and its copy. A design that applies the old polarity there, or fails to refresh the shadow word, reads back the inverted byte after the copy. It also sends a copy strobe with no load before it; a design that copies unconditionally corrupts every word from stale shadow contents. Overlapping strobes must neither toggle nor block the access in that cycle, and an erase must also clear the polarity bit, otherwise a cleared array reads back as 0xFF. Read-during-write ordering is checked as well, along with the interval of the internal sequencer.

// File: rtl/flipcell_pkg.sv
package flipcell_pkg;
  typedef struct packed {
    logic load;  // complement storage into shadow stage
    logic copy;  // shadow stage back to storage, completes inversion
  } tgl_cmd_t;
endpackage

// File: rtl/flipcell_decode.sv
module flipcell_decode #(
  parameter int ROW_BITS = 5,
  parameter int COL_BITS = 5,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS,
  localparam int ENTRIES = ROWS * COLS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  output logic [ENTRIES-1:0]           word_sel
);
  logic [ROWS-1:0] row_sel;
  logic [COLS-1:0] col_sel;
  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;

  assign row_idx = addr[ROW_BITS+COL_BITS-1:COL_BITS];
  assign col_idx = addr[COL_BITS-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = (row_idx == ROW_BITS'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel[c] = (col_idx == COL_BITS'(c));
  end
  for (genvar r = 0; r < ROWS; r++) begin : g_wr
    for (genvar c = 0; c < COLS; c++) begin : g_wc
      assign word_sel[r*COLS+c] = row_sel[r] & col_sel[c];
    end
  end

  // R1: exactly one word is selected by any address
  p_one_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word_sel) == 1);
endmodule

// File: rtl/flipcell_phase.sv
module flipcell_phase
  import flipcell_pkg::*;
#(
  parameter bit INT_TOGGLE    = 1'b0,
  parameter int TOGGLE_PERIOD = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     erase,
  input  logic     ext_copy,
  input  logic     ext_load,
  output tgl_cmd_t cmd,
  output logic     pol,
  output logic     err
);
  logic p_copy, p_load, armed;

  if (INT_TOGGLE) begin : g_int
    localparam int CW = (TOGGLE_PERIOD > 2) ? $clog2(TOGGLE_PERIOD) : 2;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (cnt == CW'(TOGGLE_PERIOD - 1)) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
    assign p_load = (cnt == CW'(0));
    assign p_copy = (cnt == CW'(2));
    // R9: one idle cycle separates load from copy
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      p_load |=> !p_copy);
  end else begin : g_ext
    assign p_load = ext_load;
    assign p_copy = ext_copy;
  end

  assign cmd.load = p_load & ~p_copy & ~erase;
  assign cmd.copy = p_copy & ~p_load & ~erase & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol   <= 1'b0;
      armed <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= p_copy & p_load;
      if (erase) begin
        pol   <= 1'b0;
        armed <= 1'b0;
      end else if (cmd.copy) begin
        pol   <= ~pol;
        armed <= 1'b0;
      end else if (cmd.load) begin
        armed <= 1'b1;
      end
    end
  end

  // R4: polarity flips after a completed copy, and only then
  p_pol_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.copy |=> (pol != $past(pol)));
  p_pol_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.copy && !erase) |=> $stable(pol));
  // R5: overlapping strobes raise the error pulse and do nothing else
  p_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_copy && p_load) |=> (err && $stable(pol)));
  // R6: erase returns the polarity to zero
  p_erase_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !pol);
endmodule

// File: rtl/flipcell_array.sv
module flipcell_array #(
  parameter int ENTRIES = 1024,
  parameter int WIDTH   = 8,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               erase,
  input  logic               load,
  input  logic               copy,
  input  logic               we,
  input  logic [ENTRIES-1:0] word_sel,
  input  logic [WIDTH-1:0]   wcell,
  input  logic [WIDTH-1:0]   wshadow,
  input  logic [AW-1:0]      raddr,
  output logic [WIDTH-1:0]   rword
);
  logic [WIDTH-1:0] store  [ENTRIES];
  logic [WIDTH-1:0] shadow [ENTRIES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (erase) begin
        store[i]  <= '0;
        shadow[i] <= '0;
      end else begin
        if (copy) store[i] <= shadow[i];
        if (load) shadow[i] <= ~store[i];
        if (we && word_sel[i]) begin
          store[i] <= wcell;
          if (!copy) shadow[i] <= wshadow;
        end
      end
    end
  end

  assign rword = store[raddr];
endmodule

// File: rtl/flipcell_ram.sv
module flipcell_ram
  import flipcell_pkg::*;
#(
  parameter int  ROW_BITS      = 5,
  parameter int  COL_BITS      = 5,
  parameter int  WIDTH         = 8,
  parameter bit  INT_TOGGLE    = 1'b0,
  parameter int  TOGGLE_PERIOD = 64,
  localparam int AW      = ROW_BITS + COL_BITS,
  localparam int ENTRIES = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             erase,
  input  logic             tgl_copy,
  input  logic             tgl_load,
  output logic             inv_state,
  output logic             phase_err
);
  tgl_cmd_t         cmd;
  logic             pol;
  logic [ENTRIES-1:0] word_sel;
  logic [WIDTH-1:0] rword, wcell, wshadow;
  logic             wpol, we;

  flipcell_decode #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .word_sel(word_sel));

  flipcell_phase #(.INT_TOGGLE(INT_TOGGLE), .TOGGLE_PERIOD(TOGGLE_PERIOD)) u_phase (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ext_copy(tgl_copy),
    .ext_load(tgl_load), .cmd(cmd), .pol(pol), .err(phase_err));

  // a write alongside a copy must be stored in the polarity the copy creates
  assign wpol    = cmd.copy ? ~pol : pol;
  assign we      = wr_en & ~erase;
  assign wcell   = wr_data ^ {WIDTH{wpol}};
  assign wshadow = ~(wr_data ^ {WIDTH{pol}});

  flipcell_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_arr (
    .clk(clk), .erase(erase), .load(cmd.load), .copy(cmd.copy), .we(we),
    .word_sel(word_sel), .wcell(wcell), .wshadow(wshadow), .raddr(addr),
    .rword(rword));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (erase) rd_data <= '0;
    else if (rd_en) rd_data <= rword ^ {WIDTH{pol}};
  end

  assign inv_state = pol;

  // R6: erase forces the read register to zero
  p_erase_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (rd_data == '0));
  // R8: read data holds without a read or erase
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !erase) |=> $stable(rd_data));
endmodule

// File: tb/flipcell_ram_test.sv
module flipcell_ram_test;
  localparam int RB = 2, CB = 2, W = 8, N = 16, GP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [RB+CB-1:0] addr = '0;
  logic wr_en = 0, rd_en = 0, erase = 0, tcopy = 0, tload = 0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic inv_state, phase_err;

  logic [RB+CB-1:0] g_addr = '0;
  logic g_wr = 0, g_rd = 0;
  logic [W-1:0] g_wd = '0, g_rdata;
  logic g_inv, g_err;

  flipcell_ram #(.ROW_BITS(RB), .COL_BITS(CB), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .erase(erase), .tgl_copy(tcopy),
    .tgl_load(tload), .inv_state(inv_state), .phase_err(phase_err));

  flipcell_ram #(.ROW_BITS(RB), .COL_BITS(CB), .WIDTH(W), .INT_TOGGLE(1'b1),
                 .TOGGLE_PERIOD(GP)) uut_gen (
    .clk(clk), .rst_n(rst_n), .addr(g_addr), .wr_en(g_wr), .wr_data(g_wd),
    .rd_en(g_rd), .rd_data(g_rdata), .erase(1'b0), .tgl_copy(1'b1),
    .tgl_load(1'b1), .inv_state(g_inv), .phase_err(g_err));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] model [N];
  logic pol_m = 0;

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int a, input int s);
    return W'((a * 37 + s * 11 + 5) % 256);
  endfunction

  task automatic wr(input int a, input logic [W-1:0] d);
    addr = a[RB+CB-1:0]; wr_data = d; wr_en = 1; step(); wr_en = 0;
    model[a] = d;
  endtask

  task automatic rd(input int a, input string req);
    addr = a[RB+CB-1:0]; rd_en = 1; step(); rd_en = 0;
    chk(req, rd_data, model[a]);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < N; a++) rd(a, req);
  endtask

  task automatic toggle_pair();
    tload = 1; step(); tload = 0; step();
    tcopy = 1; step(); tcopy = 0;
    pol_m = ~pol_m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(); step();
    // R10: reset values
    chk("R10 rd_data", rd_data, 0);
    chk("R10 inv_state", inv_state, 0);
    chk("R10 phase_err", phase_err, 0);
    rst_n = 1; step();

    // R6: erase then sweep to zero
    erase = 1; step(); erase = 0;
    for (int a = 0; a < N; a++) model[a] = '0;
    read_all("R6 post-erase");

    // R1: fill and read back; sweep confirms row/col decode
    for (int a = 0; a < N; a++) wr(a, pat(a, 0));
    read_all("R1 write-read");

    // R8: hold without read
    rd(5, "R8 read");
    step(); step();
    chk("R8 hold", rd_data, model[5]);

    // R2: read and write together return old data
    addr = 3; wr_data = 8'h3C; wr_en = 1; rd_en = 1; step(); wr_en = 0; rd_en = 0;
    chk("R2 old data", rd_data, model[3]);
    model[3] = 8'h3C;
    rd(3, "R2 new data");

    // R3/R4: inversions keep data, polarity tracks
    for (int k = 0; k < 3; k++) begin
      toggle_pair();
      chk("R4 polarity", inv_state, pol_m);
      read_all("R3 after inversion");
    end

    // R4: copy without a preceding load does nothing
    tcopy = 1; step(); tcopy = 0; step();
    chk("R4 bare copy polarity", inv_state, pol_m);
    read_all("R4 bare copy data");

    // R7: write in the copy cycle
    tload = 1; step(); tload = 0;
    addr = 7; wr_data = 8'h5A; tcopy = 1; wr_en = 1; step(); tcopy = 0; wr_en = 0;
    model[7] = 8'h5A; pol_m = ~pol_m;
    chk("R7 polarity", inv_state, pol_m);
    rd(7, "R7 write with copy");

    // R7: write in the load cycle and between load and copy
    addr = 2; wr_data = 8'hC3; tload = 1; wr_en = 1; step(); tload = 0; wr_en = 0;
    model[2] = 8'hC3;
    wr(9, 8'h81);
    tcopy = 1; step(); tcopy = 0; pol_m = ~pol_m;
    read_all("R7 writes around toggle");

    // R5: overlapping strobes
    addr = 4; wr_data = 8'hE7; wr_en = 1; tcopy = 1; tload = 1; step();
    wr_en = 0; tcopy = 0; tload = 0;
    model[4] = 8'hE7;
    chk("R5 err pulse", phase_err, 1);
    chk("R5 polarity held", inv_state, pol_m);
    step();
    chk("R5 err one cycle", phase_err, 0);
    read_all("R5 data after clash");
    tcopy = 1; step(); tcopy = 0;
    chk("R5 no load armed", inv_state, pol_m);

    // R6: erase with access in same cycle, polarity nonzero beforehand
    if (!pol_m) toggle_pair();
    chk("R6 polarity before erase", inv_state, 1);
    rd(6, "R6 pre-erase read");
    addr = 6; wr_data = 8'h11; wr_en = 1; rd_en = 1; erase = 1; step();
    wr_en = 0; rd_en = 0; erase = 0;
    chk("R6 rd_data zero", rd_data, 0);
    chk("R6 polarity zero", inv_state, 0);
    pol_m = 0;
    for (int a = 0; a < N; a++) model[a] = '0;
    read_all("R6 erased");

    // R9: internal sequencer period and data integrity
    g_addr = 1; g_wd = 8'hA5; g_wr = 1; step(); g_wr = 0;
    begin
      logic last;
      int gap = 0, cnt = 0, waited = 0;
      last = g_inv;
      while (cnt < 3 && waited < 200) begin
        step(); waited++; gap++;
        if (g_inv !== last) begin
          last = g_inv;
          if (cnt > 0) chk("R9 period", gap, GP);
          gap = 0; cnt++;
        end
        chk("R9 ext pins ignored", g_err, 0);
      end
      chk("R9 toggles seen", cnt, 3);
    end
    for (int k = 0; k < GP; k++) begin
      g_addr = 1; g_rd = 1; step(); g_rd = 0;
      chk("R9 data stable", g_rdata, 8'hA5);
    end

    finish_run();
  end
endmodule